// File: doc/BRIEF.md
# Edit-Distance Array Sweep Controller

This block walks an edit-distance dynamic programming array one cell at a time and drives the memory and the datapath around it. The host supplies two sequence lengths and a start pulse. The block latches the lengths and visits every cell of the (lenA+1) x (lenB+1) array in row-major order. For each cell it produces the linear word address of the cell and the addresses of its left, upper and upper-left neighbours.

Each cell takes a fixed six-cycle slot. The first three cycles read the three neighbours, the fourth strobes the compute result and the fifth writes the cell back. The sixth cycle moves the row and column counters on. Cells in row 0 or column 0 have no neighbours. For these cells the reads are skipped and a boundary flag is raised, so the datapath writes an initial value instead.

Two equality comparators find the end of a row and the end of the array, so the sweep stops by itself after the last write. Before a sweep is accepted, the block checks that the array fits the 2^22-word store. A clock enable freezes all progress.

Top module: `dp_sweep_ctrl`

## Requirements
- R1: A start pulse is taken only on a cycle where `en` is high and no sweep is running; a start during a sweep has no effect on the cell sequence.
- R2: Cells are visited in row-major order, `row` from 0 to lenA and `col` from 0 to lenB, both inclusive, with `row`/`col` showing the current cell.
- R3: Each cell occupies exactly six enabled cycles, phases 0..5. In phases 0, 1 and 2, `rd_stb` reads the left (`rd_sel`=0), upper (`rd_sel`=1) and upper-left (`rd_sel`=2) neighbour. Phase 3 raises `cmp_stb`, phase 4 raises `wr_stb`, and phase 5 raises no strobe.
- R4: `addr_cur` equals row*(lenB+1)+col.
- R5: For an interior cell, `addr_left` = addr_cur-1, `addr_up` = addr_cur-(lenB+1) and `addr_diag` = addr_cur-(lenB+1)-1.
- R6: For a cell in row 0 or column 0, `bnd_init` is high, `rd_stb` stays low and the three neighbour addresses are 0. The compute and write strobes still occur.
- R7: In the cycle after the last cell's sixth cycle, `busy` falls and `done` rises. `done` holds until the next start.
- R8: A start with (lenA+1)*(lenB+1) > 2^22 raises `err`, starts no sweep and never raises `done`. A product of exactly 2^22 is accepted, and an accepted start clears `err`.
- R9: While `en` is low, the counters, addresses and strobes hold their values.
- R10: After reset, `busy`, `done`, `err` and every strobe are 0.
- R11: At most one of `rd_stb`, `cmp_stb` and `wr_stb` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable; low freezes the block |
| start | input | 1 | Begin a sweep with the given lengths |
| len_a | input | 16 | Length of sequence A (rows are 0..len_a) |
| len_b | input | 16 | Length of sequence B (columns are 0..len_b) |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Last cell written |
| err | output | 1 | Last start rejected for size |
| row | output | 16 | Current row index |
| col | output | 16 | Current column index |
| addr_cur | output | 22 | Word address of the current cell |
| addr_left | output | 22 | Address of the left neighbour |
| addr_up | output | 22 | Address of the upper neighbour |
| addr_diag | output | 22 | Address of the upper-left neighbour |
| rd_stb | output | 1 | Neighbour read strobe |
| rd_sel | output | 2 | Neighbour being read: 0 left, 1 up, 2 upper-left |
| cmp_stb | output | 1 | Compute-result strobe |
| wr_stb | output | 1 | Write-back strobe |
| bnd_init | output | 1 | Current cell lies on row 0 or column 0 |

## Verification
The bench follows every enabled cycle of each sweep with its own model of cell index and phase. This covers degenerate shapes such as a single cell, one row and one column. A design that wraps a counter one step early or late skips or repeats cells, and the model shows that as a wrong address or an early `done`. The size check is tested on both sides of 2^22, so an off-by-one in the comparison either rejects a legal array or starts an illegal one. Random enable gaps and start pulses during a sweep catch a design that advances while disabled or restarts in mid-sweep.

// File: rtl/dps_pkg.sv
package dps_pkg;
  typedef enum logic [2:0] {
    PH_RD_L = 3'd0,
    PH_RD_U = 3'd1,
    PH_RD_D = 3'd2,
    PH_CMP  = 3'd3,
    PH_WR   = 3'd4,
    PH_ADV  = 3'd5
  } phase_e;
endpackage

// File: rtl/dps_cell_timer.sv
module dps_cell_timer
  import dps_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   clr,
  input  logic   run,
  output phase_e ph_q,
  output phase_e ph_d
);
  always_comb begin
    ph_d = ph_q;
    if (clr)
      ph_d = PH_RD_L;
    else if (run)
      ph_d = (ph_q == PH_ADV) ? PH_RD_L : phase_e'(ph_q + 3'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_RD_L;
    else     ph_q <= ph_d;
  end
endmodule

// File: rtl/dps_index_ctr.sv
module dps_index_ctr #(
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  input  logic [IDX_W-1:0]  lim_row,
  input  logic [IDX_W-1:0]  lim_col,
  input  logic [ADDR_W-1:0] stride,
  output logic [IDX_W-1:0]  row_q,
  output logic [IDX_W-1:0]  col_q,
  output logic [IDX_W-1:0]  row_d,
  output logic [IDX_W-1:0]  col_d,
  output logic [ADDR_W-1:0] base_d,
  output logic              last_cell
);
  logic [ADDR_W-1:0] base_q;
  logic              row_end;

  assign row_end   = (col_q == lim_col);
  assign last_cell = row_end && (row_q == lim_row);

  always_comb begin
    row_d  = row_q;
    col_d  = col_q;
    base_d = base_q;
    if (clr) begin
      row_d  = '0;
      col_d  = '0;
      base_d = '0;
    end else if (step) begin
      if (row_end) begin
        col_d = '0;
        if (!last_cell) begin
          row_d  = row_q + 1'b1;
          base_d = base_q + stride;
        end
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q  <= '0;
      col_q  <= '0;
      base_q <= '0;
    end else begin
      row_q  <= row_d;
      col_q  <= col_d;
      base_q <= base_d;
    end
  end
endmodule

// File: rtl/dps_size_check.sv
module dps_size_check #(
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 22
) (
  input  logic [IDX_W-1:0] len_a,
  input  logic [IDX_W-1:0] len_b,
  output logic             fits
);
  localparam int DIM_W  = IDX_W + 1;
  localparam int PROD_W = 2 * DIM_W;
  localparam logic [PROD_W-1:0] LIMIT = PROD_W'(1) << ADDR_W;

  logic [DIM_W-1:0]  dim_a, dim_b;
  logic [PROD_W-1:0] prod;

  assign dim_a = DIM_W'(len_a) + 1'b1;
  assign dim_b = DIM_W'(len_b) + 1'b1;
  assign prod  = PROD_W'(dim_a) * PROD_W'(dim_b);
  assign fits  = (prod <= LIMIT);
endmodule

// File: rtl/dp_sweep_ctrl.sv
module dp_sweep_ctrl
  import dps_pkg::*;
#(
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic [IDX_W-1:0]  len_a,
  input  logic [IDX_W-1:0]  len_b,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [IDX_W-1:0]  row,
  output logic [IDX_W-1:0]  col,
  output logic [ADDR_W-1:0] addr_cur,
  output logic [ADDR_W-1:0] addr_left,
  output logic [ADDR_W-1:0] addr_up,
  output logic [ADDR_W-1:0] addr_diag,
  output logic              rd_stb,
  output logic [1:0]        rd_sel,
  output logic              cmp_stb,
  output logic              wr_stb,
  output logic              bnd_init
);
  logic [IDX_W-1:0]  la_q, lb_q;
  logic [IDX_W-1:0]  row_d, col_d;
  logic [ADDR_W-1:0] base_d, stride, cur_d;
  logic              fits, start_acc, clr, step, last_cell, busy_d, bnd_d;
  phase_e            ph_q, ph_d;

  assign stride    = ADDR_W'(lb_q) + 1'b1;
  assign start_acc = en && start && !busy;
  assign clr       = start_acc && fits;
  assign step      = en && busy && (ph_q == PH_ADV);

  dps_size_check #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_size (
    .len_a(len_a), .len_b(len_b), .fits(fits)
  );

  dps_cell_timer u_timer (
    .clk(clk), .rst(rst), .clr(clr), .run(en && busy),
    .ph_q(ph_q), .ph_d(ph_d)
  );

  dps_index_ctr #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_idx (
    .clk(clk), .rst(rst), .clr(clr), .step(step),
    .lim_row(la_q), .lim_col(lb_q), .stride(stride),
    .row_q(row), .col_q(col), .row_d(row_d), .col_d(col_d),
    .base_d(base_d), .last_cell(last_cell)
  );

  always_comb begin
    busy_d = busy;
    if (clr)                    busy_d = 1'b1;
    else if (step && last_cell) busy_d = 1'b0;
  end

  assign bnd_d = (row_d == '0) || (col_d == '0);
  assign cur_d = base_d + ADDR_W'(col_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      la_q      <= '0;
      lb_q      <= '0;
      addr_cur  <= '0;
      addr_left <= '0;
      addr_up   <= '0;
      addr_diag <= '0;
      rd_stb    <= 1'b0;
      rd_sel    <= '0;
      cmp_stb   <= 1'b0;
      wr_stb    <= 1'b0;
      bnd_init  <= 1'b0;
    end else begin
      busy <= busy_d;
      if (start_acc) begin
        done <= 1'b0;
        err  <= !fits;
        if (fits) begin
          la_q <= len_a;
          lb_q <= len_b;
        end
      end else if (step && last_cell) begin
        done <= 1'b1;
      end
      addr_cur  <= cur_d;
      addr_left <= bnd_d ? '0 : cur_d - 1'b1;
      addr_up   <= bnd_d ? '0 : cur_d - stride;
      addr_diag <= bnd_d ? '0 : cur_d - stride - 1'b1;
      rd_stb    <= busy_d && !bnd_d && (ph_d <= PH_RD_D);
      rd_sel    <= (busy_d && !bnd_d && (ph_d <= PH_RD_D)) ? ph_d[1:0] : 2'd0;
      cmp_stb   <= busy_d && (ph_d == PH_CMP);
      wr_stb    <= busy_d && (ph_d == PH_WR);
      bnd_init  <= busy_d && bnd_d;
    end
  end
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
  parameter int IDX_W  = 16,
  parameter int ADDR_W = 22
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [IDX_W-1:0]  row,
  input logic [IDX_W-1:0]  col,
  input logic [ADDR_W-1:0] addr_cur,
  input logic              rd_stb,
  input logic              cmp_stb,
  input logic              wr_stb,
  input logic              bnd_init
);
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rd_stb, cmp_stb, wr_stb}));

  p_bnd_no_read_r6: assert property (@(posedge clk) disable iff (rst)
    bnd_init |-> !rd_stb);

  p_wr_after_cmp_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_stb) |-> $past(cmp_stb));

  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_done_from_busy_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy));

  p_err_no_done_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> !done);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(row) && $stable(col) && $stable(addr_cur) && $stable(wr_stb));
endmodule

bind dp_sweep_ctrl dps_checker #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .busy(busy), .done(done), .err(err),
  .row(row), .col(col), .addr_cur(addr_cur), .rd_stb(rd_stb),
  .cmp_stb(cmp_stb), .wr_stb(wr_stb), .bnd_init(bnd_init)
);

// File: tb/dp_sweep_ctrl_test.sv
module dp_sweep_ctrl_test;
  localparam int IDX_W  = 16;
  localparam int ADDR_W = 22;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, start = 1'b0;
  logic [IDX_W-1:0]  len_a = '0, len_b = '0;
  logic              busy, done, err, rd_stb, cmp_stb, wr_stb, bnd_init;
  logic [1:0]        rd_sel;
  logic [IDX_W-1:0]  row, col;
  logic [ADDR_W-1:0] addr_cur, addr_left, addr_up, addr_diag;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dp_sweep_ctrl #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .en(en), .start(start), .len_a(len_a), .len_b(len_b),
    .busy(busy), .done(done), .err(err), .row(row), .col(col),
    .addr_cur(addr_cur), .addr_left(addr_left), .addr_up(addr_up),
    .addr_diag(addr_diag), .rd_stb(rd_stb), .rd_sel(rd_sel),
    .cmp_stb(cmp_stb), .wr_stb(wr_stb), .bnd_init(bnd_init)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint exp_nb(input longint k, input int a_len, input int b_len, input int which);
    longint r = k / (b_len + 1);
    longint c = k % (b_len + 1);
    if (r == 0 || c == 0) return 0;
    case (which)
      0: return k - 1;
      1: return k - (b_len + 1);
      default: return k - (b_len + 1) - 1;
    endcase
  endfunction

  task automatic check_idle(input string tag);
    chk(busy == 0, {tag, " busy"}, busy, 0);
    chk({rd_stb, cmp_stb, wr_stb} == 0, {tag, " strobes"}, {rd_stb, cmp_stb, wr_stb}, 0);
  endtask

  task automatic run_case(input int a_len, input int b_len, input int en_pct, input bit poke_start);
    longint n = longint'(a_len + 1) * longint'(b_len + 1);
    longint t = 0;
    @(negedge clk);
    len_a = IDX_W'(a_len); len_b = IDX_W'(b_len);
    en = 1'b1; start = 1'b1;
    @(posedge clk);
    forever begin
      @(negedge clk);
      start = 1'b0;
      if (t >= 6 * n) begin
        chk(done == 1, "R7 done", done, 1);
        chk(busy == 0, "R7 busy", busy, 0);
        chk(err == 0, "R8 err clear", err, 0);
        break;
      end else begin
        longint k = t / 6;
        int ph = int'(t % 6);
        longint r = k / (b_len + 1);
        longint c = k % (b_len + 1);
        bit bnd = (r == 0 || c == 0);
        chk(busy == 1 && done == 0, "R7 busy during sweep", {busy, done}, 2);
        chk(row == r, "R2 row", row, r);
        chk(col == c, "R2 col", col, c);
        chk(addr_cur == k, "R4 addr_cur", addr_cur, k);
        chk(addr_left == exp_nb(k, a_len, b_len, 0), "R5 R6 addr_left", addr_left, exp_nb(k, a_len, b_len, 0));
        chk(addr_up == exp_nb(k, a_len, b_len, 1), "R5 R6 addr_up", addr_up, exp_nb(k, a_len, b_len, 1));
        chk(addr_diag == exp_nb(k, a_len, b_len, 2), "R5 R6 addr_diag", addr_diag, exp_nb(k, a_len, b_len, 2));
        chk(bnd_init == bnd, "R6 bnd_init", bnd_init, bnd);
        chk(rd_stb == (!bnd && ph < 3), "R3 rd_stb", rd_stb, (!bnd && ph < 3));
        chk(rd_sel == ((!bnd && ph < 3) ? ph : 0), "R3 rd_sel", rd_sel, (!bnd && ph < 3) ? ph : 0);
        chk(cmp_stb == (ph == 3), "R3 cmp_stb", cmp_stb, ph == 3);
        chk(wr_stb == (ph == 4), "R3 wr_stb", wr_stb, ph == 4);
      end
      en = (($urandom % 100) < en_pct);
      if (poke_start && ($urandom % 8 == 0)) begin
        start = 1'b1;  // R1: ignored while busy
        len_a = IDX_W'($urandom % 4);
        len_b = IDX_W'($urandom % 4);
      end
      @(posedge clk);
      if (en) t++;  // R9: disabled cycles do not advance
    end
    en = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 0 && done == 0 && err == 0, "R10 reset flags", {busy, done, err}, 0);
    check_idle("R10");

    // R1: start with enable low is not taken
    en = 1'b0; start = 1'b1; len_a = 16'd2; len_b = 16'd2;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 0, "R1 start without en", busy, 0);

    run_case(0, 0, 100, 0);
    run_case(0, 4, 100, 0);
    run_case(3, 0, 100, 0);
    run_case(2, 3, 60, 1);
    for (int i = 0; i < 10; i++)
      run_case(int'($urandom % 6), int'($urandom % 6), 75, 1);

    // R8: one past the limit is rejected
    @(negedge clk);
    len_a = 16'd2048; len_b = 16'd2047; en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1, "R8 oversize err", err, 1);
    chk(done == 0, "R8 done cleared", done, 0);
    repeat (20) @(negedge clk);
    chk(busy == 0 && done == 0, "R8 no sweep after reject", {busy, done}, 0);

    run_case(1, 2, 100, 0);  // accepted start clears err

    // R8: exactly at the limit is accepted
    @(negedge clk);
    len_a = 16'd2047; len_b = 16'd2047; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1 && err == 0, "R8 limit accepted", {busy, err}, 2);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && err == 0, "R10 reset mid-sweep", {busy, done, err}, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule